// File: doc/BRIEF.md
# Opcode-Fetch Wait-State Inserter

This block sits beside the bus of an 8-bit CPU with Z80-style timing. The CPU exposes an opcode-fetch strobe (M1), a memory-request strobe and an I/O-request strobe, all active low. The block watches these strobes and drives an active-low WAIT line. Each opcode-fetch machine cycle is then stretched by a fixed number of clocks, one by default. The read part of a fetch becomes as long as an ordinary memory read, and the refresh part that follows is left alone. With the default, a no-operation instruction costs 5 clocks instead of 4.

The block samples the strobes on the rising clock edge, one sample per T-state. A fetch is recognised when M1 and MREQ are both low and IORQ is high. The stretch starts in the following T-state, where the CPU samples WAIT. One stretch is produced per low period of M1, and the block only re-arms once M1 has been seen high again.

Interrupt acknowledge also drives M1 low, but with MREQ high. It gets no extra wait, because the CPU already adds its own. Operand and displacement reads, refresh, I/O and internal cycles are never touched. Other wait sources are ORed onto the CPU pin outside this block.

Top module: `opfetch_wait`

## Requirements
- R1: While rst_n is low, and on the first clock after it, wait_n is 1. A fetch already under way when reset is released gets no wait, because the block arms only after m1_n has been sampled high.
- R2: When a rising edge samples m1_n=0, mreq_n=0 and iorq_n=1 while the block is armed, wait_n is 0 for exactly WAIT_CLOCKS clocks starting from that edge. It is 1 at all other times.
- R3: An opcode fetch lasts 4+WAIT_CLOCKS T-states. With the default of 1, a no-operation instruction takes 5 clocks.
- R4: A single low period of m1_n gets at most one wait burst, even if m1_n and mreq_n stay low far longer than a normal fetch.
- R5: During the refresh T-states of a fetch (m1_n=1, mreq_n=0), wait_n stays 1, and the refresh part still lasts 2 T-states.
- R6: Memory reads with m1_n=1, such as operand and displacement bytes, get no wait and last 3 T-states.
- R7: Interrupt acknowledge (m1_n=0 with mreq_n=1, then iorq_n=0) gets no wait and keeps its 6 T-states.
- R8: Memory writes (3 T-states), I/O cycles (4 T-states) and internal cycles keep their lengths.
- R9: An indexed ALU instruction with a memory operand runs as machine cycles of 5, 5, 3, 5 and 3 T-states when WAIT_CLOCKS is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; one rising edge per T-state |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_m1_n | input | 1 | Opcode-fetch strobe from the CPU, active low |
| cpu_mreq_n | input | 1 | Memory-request strobe from the CPU, active low |
| cpu_iorq_n | input | 1 | I/O-request strobe from the CPU, active low |
| wait_n | output | 1 | Wait request to the CPU, active low, registered |

## Verification
The bench builds the block with WAIT_CLOCKS at its default of 1. This makes the stretched fetch 5 T-states, so a scripted indexed ALU instruction can be compared with the 5, 5, 3, 5, 3 pattern. A bus model in the bench samples wait_n where the CPU would and inserts a T-state for each low sample, so every cycle's length comes from the design's real output. Expected lengths are written in terms of the parameter, which means a build with 2 checks the counter variant of the timer against 6-T-state fetches with no other change.

// File: rtl/opfetch_wait_pkg.sv
// Package: shared bus-cycle classification for the opcode-fetch wait inserter.
// Assumes all strobes are active low and already synchronous to the CPU clock.
package opfetch_wait_pkg;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_FETCH  = 2'd1,
        BUS_INTACK = 2'd2,
        BUS_OTHER  = 2'd3
    } bus_kind_e;

    // Classifies one sampled set of strobes into a kind of bus activity.
    function automatic bus_kind_e classify_bus(input logic m1_n,
                                               input logic mreq_n,
                                               input logic iorq_n);
        bus_kind_e k;
        if (!m1_n && !mreq_n && iorq_n)
            k = BUS_FETCH;
        else if (!m1_n && mreq_n)
            k = BUS_INTACK;
        else if (!mreq_n || !iorq_n)
            k = BUS_OTHER;
        else
            k = BUS_IDLE;
        return k;
    endfunction

endpackage

// File: rtl/opfetch_arm.sv
// Module: opfetch_arm
// Decides when a wait burst starts. It raises fire for the single clock
// in which an armed block sees an opcode fetch. The block arms when M1 is
// sampled high. It disarms when it fires, or when M1 appears without MREQ
// (interrupt acknowledge).
// Assumes: strobes are synchronous to clk; the kind input comes from classify_bus.
module opfetch_arm
    import opfetch_wait_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      m1_n,
    input  bus_kind_e kind,
    output logic      fire
);

    logic armed_q;

    // Start a burst only on a fetch while armed.
    always_comb begin
        fire = armed_q && (kind == BUS_FETCH);
    end

    // Arm on M1 high; disarm on a burst start or an acknowledge cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (m1_n)
            armed_q <= 1'b1;
        else if (fire || kind == BUS_INTACK)
            armed_q <= 1'b0;
    end

endmodule

// File: rtl/stretch_timer.sv
// Module: stretch_timer
// Holds the registered wait output low for WAIT_CLOCKS clocks after a
// fire pulse. A parameter selects the variant: a single flip-flop when the
// stretch is one clock, and a down-counter when it is longer.
// Assumes: fire never arrives while a burst is still running.
module stretch_timer #(
    parameter int WAIT_CLOCKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic wait_n
);

    localparam int CW = (WAIT_CLOCKS > 1) ? $clog2(WAIT_CLOCKS + 1) : 1;

    generate
        if (WAIT_CLOCKS <= 1) begin : g_single
            logic hold_q;

            // One-clock stretch: the flop mirrors the fire pulse.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    hold_q <= 1'b0;
                else
                    hold_q <= fire;
            end

            assign wait_n = !hold_q;
        end else begin : g_count
            logic [CW-1:0] left_q;
            logic [CW-1:0] left_d;
            logic          wait_q;

            // Next count: load on a fire pulse, otherwise count down to zero.
            always_comb begin
                if (fire)
                    left_d = CW'(WAIT_CLOCKS);
                else if (left_q != '0)
                    left_d = left_q - 1'b1;
                else
                    left_d = '0;
            end

            // Register the count and the wait level derived from it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    left_q <= '0;
                    wait_q <= 1'b1;
                end else begin
                    left_q <= left_d;
                    wait_q <= (left_d == '0);
                end
            end

            assign wait_n = wait_q;
        end
    endgenerate

endmodule

// File: rtl/opfetch_wait.sv
// Module: opfetch_wait (top)
// Stretches every opcode-fetch machine cycle by WAIT_CLOCKS clocks by
// driving an active-low wait line. Fetches are recognised from M1 and MREQ
// both low with IORQ high, sampled on the rising edge that ends T1.
// Assumes: one rising edge per T-state, and that the CPU samples wait in T2.
module opfetch_wait
    import opfetch_wait_pkg::*;
#(
    parameter int WAIT_CLOCKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_m1_n,
    input  logic cpu_mreq_n,
    input  logic cpu_iorq_n,
    output logic wait_n
);

    bus_kind_e kind;
    logic      fire;

    // Classify the current strobe levels.
    always_comb begin
        kind = classify_bus(cpu_m1_n, cpu_mreq_n, cpu_iorq_n);
    end

    opfetch_arm u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .m1_n  (cpu_m1_n),
        .kind  (kind),
        .fire  (fire)
    );

    stretch_timer #(.WAIT_CLOCKS(WAIT_CLOCKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire   (fire),
        .wait_n (wait_n)
    );

endmodule

// File: rtl/opfetch_wait_chk.sv
// Module: opfetch_wait_chk
// Checks the timing of the wait output against the bus strobes, using only
// the ports of opfetch_wait. It is attached to the top module with bind.
module opfetch_wait_chk #(
    parameter int WAIT_CLOCKS = 1
) (
    input logic clk,
    input logic rst_n,
    input logic cpu_m1_n,
    input logic cpu_mreq_n,
    input logic cpu_iorq_n,
    input logic wait_n
);

    localparam int LW = $clog2(WAIT_CLOCKS + 2);

    logic [LW-1:0] low_run;
    logic          burst_in_m1;

    // Count consecutive low samples of wait_n, stopping at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_run <= '0;
        else if (wait_n)
            low_run <= '0;
        else if (low_run != {LW{1'b1}})
            low_run <= low_run + 1'b1;
    end

    // Remember whether a burst has begun during the current M1-low period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            burst_in_m1 <= 1'b0;
        else
            burst_in_m1 <= !cpu_m1_n && (burst_in_m1 || (!wait_n && $past(wait_n)));
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> wait_n);

    // R2
    start_on_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_n) |-> $past(!cpu_m1_n && !cpu_mreq_n && cpu_iorq_n));

    // R2
    burst_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wait_n) |-> low_run == LW'(WAIT_CLOCKS));

    // R2
    burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_n |-> low_run < LW'(WAIT_CLOCKS));

    // R4
    one_burst_per_m1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_n) |-> !burst_in_m1);

    // R7
    no_intack_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wait_n) |-> $past(cpu_iorq_n && !cpu_mreq_n));

endmodule

bind opfetch_wait opfetch_wait_chk #(.WAIT_CLOCKS(WAIT_CLOCKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_m1_n   (cpu_m1_n),
    .cpu_mreq_n (cpu_mreq_n),
    .cpu_iorq_n (cpu_iorq_n),
    .wait_n     (wait_n)
);

// File: tb/test_opfetch_wait.sv
`timescale 1ns/1ps
// Bench: a bus model plays scripted machine cycles, sampling wait_n in the
// way the CPU would. It pushes the expected length of each cycle into a
// queue, and a monitor measures the real lengths and compares them.
module test_opfetch_wait;

    localparam int W = 1;

    logic clk    = 1'b0;
    logic rst_n  = 1'b0;
    logic m1_n   = 1'b1;
    logic mreq_n = 1'b1;
    logic iorq_n = 1'b1;
    logic mark   = 1'b0;
    logic wait_n;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    string tag_q[$];
    int run_len = 0;

    always #2.5 clk = ~clk;

    opfetch_wait #(.WAIT_CLOCKS(W)) i_opfetch_wait (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_m1_n   (m1_n),
        .cpu_mreq_n (mreq_n),
        .cpu_iorq_n (iorq_n),
        .wait_n     (wait_n)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance to the middle of the next T-state.
    task automatic tstate();
        @(negedge clk);
        mark = 1'b0;
    endtask

    task automatic begin_cycle(input int len, input string tag);
        exp_q.push_back(len);
        tag_q.push_back(tag);
        @(negedge clk);
        mark = 1'b1;
    endtask

    // Insert one T-state for every low sample of wait_n.
    task automatic honour_wait();
        while (!wait_n) tstate();
    endtask

    task automatic op_fetch(input string tag);
        begin_cycle(4 + W, tag);
        m1_n = 1'b0; mreq_n = 1'b0;
        tstate();
        check(wait_n == 1'b0, "R2 wait in T2", int'(wait_n), 0);
        honour_wait();
        tstate();
        m1_n = 1'b1; mreq_n = 1'b0;
        check(wait_n == 1'b1, "R5 refresh T3", int'(wait_n), 1);
        tstate();
        mreq_n = 1'b1;
        check(wait_n == 1'b1, "R5 refresh T4", int'(wait_n), 1);
    endtask

    task automatic mem_access(input string tag);
        begin_cycle(3, tag);
        mreq_n = 1'b0;
        tstate();
        check(wait_n == 1'b1, {tag, " no wait"}, int'(wait_n), 1);
        honour_wait();
        tstate();
        mreq_n = 1'b1;
    endtask

    task automatic io_access();
        begin_cycle(4, "R8 io");
        tstate();
        iorq_n = 1'b0;
        tstate();
        honour_wait();
        tstate();
        iorq_n = 1'b1;
    endtask

    task automatic internal_ops(input int n, input string tag);
        begin_cycle(n, tag);
        for (int i = 1; i < n; i++) tstate();
    endtask

    task automatic int_ack();
        begin_cycle(6, "R7 intack");
        m1_n = 1'b0;
        tstate();
        tstate();
        iorq_n = 1'b0;
        tstate();
        check(wait_n == 1'b1, "R7 no wait", int'(wait_n), 1);
        honour_wait();
        tstate();
        m1_n = 1'b1; iorq_n = 1'b1; mreq_n = 1'b0;
        tstate();
        mreq_n = 1'b1;
    endtask

    // M1 held low well past a normal fetch: only one burst is allowed.
    task automatic long_m1();
        begin_cycle(7 + W, "R4 long M1");
        m1_n = 1'b0; mreq_n = 1'b0;
        tstate();
        honour_wait();
        for (int i = 0; i < 4; i++) begin
            tstate();
            check(wait_n == 1'b1, "R4 second burst", int'(wait_n), 1);
        end
        tstate();
        m1_n = 1'b1; mreq_n = 1'b1;
    endtask

    // Monitor: measure each cycle between start marks and compare.
    always @(posedge clk) begin
        if (mark) begin
            if (run_len > 0) begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(run_len == e, {t, " length"}, run_len, e);
            end
            run_len = 1;
        end else if (run_len > 0) begin
            run_len++;
        end
    end

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset holds wait_n high even with fetch strobes active.
        m1_n = 1'b0; mreq_n = 1'b0;
        repeat (4) @(negedge clk);
        check(wait_n == 1'b1, "R1 in reset", int'(wait_n), 1);
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(wait_n == 1'b1, "R1 unarmed fetch", int'(wait_n), 1);
        end
        m1_n = 1'b1; mreq_n = 1'b1;
        @(negedge clk);

        // R3: back-to-back no-operation fetches.
        op_fetch("R3 nop");
        op_fetch("R3 nop");
        op_fetch("R3 nop");
        // R9: indexed ALU instruction with a memory operand.
        op_fetch("R9 prefix");
        op_fetch("R9 opcode");
        mem_access("R6 displacement");
        internal_ops(5, "R9 internal");
        mem_access("R9 operand");
        // R8: other cycle kinds keep their lengths.
        op_fetch("R3 fetch");
        mem_access("R8 write");
        io_access();
        internal_ops(2, "R8 internal");
        // R7: acknowledge, then a fetch still gets its wait.
        int_ack();
        op_fetch("R3 after intack");
        // R4: long M1 period, then a normal fetch.
        long_m1();
        op_fetch("R3 after long M1");

        // Flush the last cycle through the monitor.
        @(negedge clk);
        mark = 1'b1;
        @(negedge clk);
        mark = 1'b0;
        check(exp_q.size() == 0, "scoreboard empty", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule